// File: doc/BRIEF.md
# D-PHY Test Port Register Writer

This block loads one 8-bit configuration register inside a D-PHY through the PHY's four-wire test port. The wires are a clear line, a strobe, an enable and an 8-bit data bus. A controller supplies a register code and a data byte, then pulses `start_i`. The block plays a fixed sequence of port states and holds each state for a programmable number of system clocks, so that the PHY's setup and hold times are met. It reports completion with a one-cycle `done_o` pulse.

The PHY captures the code as an address on a falling strobe edge while the enable is high. It captures the data byte on a rising strobe edge while the enable is low. A typical use is to program the high-speed frequency-range selection into PHY register code 0x44 before lane bring-up. The package exports that code as a constant.

Top module: `dphy_tst_writer`

## Requirements
- R1: While and after reset, all port wires (`tst_clr_o`, `tst_clk_o`, `tst_en_o`, `tst_data_o`) are low, and `busy_o` and `done_o` are low.
- R2: A `start_i` sampled high at a clock edge while idle is accepted. From the next cycle `busy_o` is high and the first state is clear: `tst_clr_o`=1 with strobe, enable and bus all low.
- R3: After the clear state the port passes through seven more states, in this order: all low; strobe high with enable low and bus zero; strobe high with enable high and bus = code; strobe low with enable high and bus = code; strobe low with enable low and bus = data; strobe high with enable low and bus = data; strobe low with enable low and bus = data.
- R4: Each of the eight states lasts H system clocks, where H is `hold_i` sampled at acceptance and a value of 0 is taken as 1. `busy_o` is therefore high for exactly 8·H cycles.
- R5: During a write the strobe falls exactly once while the enable is high, and the bus then carries the accepted code.
- R6: The strobe rises only while the enable is low. The last such rise in a write occurs with the bus carrying the accepted data byte.
- R7: In the cycle after the final state ends, `done_o` is high for exactly one cycle, `busy_o` is low and all port wires are low. A new `start_i` is accepted in that cycle.
- R8: A `start_i` received while `busy_o` is high is ignored. Code, data and hold values presented with it do not alter the running write or its timing.
- R9: Writing the frequency-range value to register code 0x44 produces that code on the falling capture edge and the value on the rising capture edge.
- R10: `tst_clr_o` is never high while the strobe or enable is high or the bus is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request one register write |
| code_i | input | 8 | PHY register code (address) |
| wdata_i | input | 8 | Byte to load into the register |
| hold_i | input | HOLD_W | System clocks per port state (0 means 1) |
| busy_o | output | 1 | Write in progress |
| done_o | output | 1 | One-cycle completion pulse |
| tst_clr_o | output | 1 | Test-port clear |
| tst_clk_o | output | 1 | Test-port strobe |
| tst_en_o | output | 1 | Test-port enable (high marks an address) |
| tst_data_o | output | 8 | Test-port data bus |

## Verification
The bench checks the captured pair from a behavioural PHY model. A design that swapped the enable level at either strobe edge would latch the data as the address, or drop the write altogether. Hold values of 0, 1, 3 and 255 expose off-by-one step lengths and a zero hold that wraps the timer into a 256-cycle step. A start pulse with different code, data and hold in mid-write catches a design that re-latches inputs or restarts while busy. A start on the exact `done_o` cycle catches a sequencer that loses the back-to-back request.

// File: rtl/dtw_pkg.sv
package dtw_pkg;

    localparam int TST_W = 8;
    localparam int NSTEP = 8;
    localparam int STEP_W = $clog2(NSTEP);

    // register code that receives the high-speed frequency-range selection
    localparam logic [TST_W-1:0] HSFREQ_REG = 8'h44;

    typedef enum logic [STEP_W-1:0] {
        ST_CLR    = 3'd0,
        ST_GAP    = 3'd1,
        ST_RISE0  = 3'd2,
        ST_ADDR   = 3'd3,
        ST_ALATCH = 3'd4,
        ST_DATA   = 3'd5,
        ST_DLATCH = 3'd6,
        ST_END    = 3'd7
    } step_e;

    typedef struct packed {
        logic             clr;
        logic             stb;
        logic             en;
        logic [TST_W-1:0] bus;
    } port_t;

    localparam port_t PORT_IDLE = '{clr: 1'b0, stb: 1'b0, en: 1'b0, bus: '0};

    function automatic port_t port_for_step(step_e s, logic [TST_W-1:0] code,
                                            logic [TST_W-1:0] data);
        port_t p;
        p = PORT_IDLE;
        case (s)
            ST_CLR:    p.clr = 1'b1;
            ST_GAP:    p = PORT_IDLE;
            ST_RISE0:  p.stb = 1'b1;
            ST_ADDR:   begin p.stb = 1'b1; p.en = 1'b1; p.bus = code; end
            ST_ALATCH: begin p.en = 1'b1; p.bus = code; end
            ST_DATA:   p.bus = data;
            ST_DLATCH: begin p.stb = 1'b1; p.bus = data; end
            ST_END:    p.bus = data;
            default:   p = PORT_IDLE;
        endcase
        return p;
    endfunction

    function automatic logic [31:0] eff_hold(logic [31:0] h);
        return (h == 0) ? 32'd1 : h;
    endfunction

endpackage

// File: rtl/dtw_hold_timer.sv
module dtw_hold_timer #(
    parameter int HOLD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [HOLD_W-1:0] hold_cfg,
    input  logic              active,
    output logic              step_end
);
    logic [HOLD_W-1:0] len_q;
    logic [HOLD_W-1:0] cnt_q;
    logic              last;

    assign last     = (cnt_q == len_q - 1'b1);
    assign step_end = active && last;

    always_ff @(posedge clk) begin
        if (rst) begin
            len_q <= {{(HOLD_W-1){1'b0}}, 1'b1};
            cnt_q <= '0;
        end else if (load) begin
            len_q <= (hold_cfg == '0) ? {{(HOLD_W-1){1'b0}}, 1'b1} : hold_cfg;
            cnt_q <= '0;
        end else if (active) begin
            cnt_q <= last ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/dtw_step_seq.sv
module dtw_step_seq
    import dtw_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [TST_W-1:0] code_in,
    input  logic [TST_W-1:0] data_in,
    input  logic             step_end,
    output logic             accept,
    output logic             busy,
    output logic             done,
    output step_e            step,
    output logic [TST_W-1:0] code_q,
    output logic [TST_W-1:0] data_q
);
    step_e step_q;
    logic  busy_q;
    logic  done_q;

    assign accept = start && !busy_q;
    assign busy   = busy_q;
    assign done   = done_q;
    assign step   = step_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            step_q <= ST_CLR;
            busy_q <= 1'b0;
            done_q <= 1'b0;
            code_q <= '0;
            data_q <= '0;
        end else if (accept) begin
            step_q <= ST_CLR;
            busy_q <= 1'b1;
            done_q <= 1'b0;
            code_q <= code_in;
            data_q <= data_in;
        end else if (busy_q && step_end) begin
            if (step_q == ST_END) begin
                busy_q <= 1'b0;
                done_q <= 1'b1;
                step_q <= ST_CLR;
            end else begin
                step_q <= step_e'(step_q + 1'b1);
                done_q <= 1'b0;
            end
        end else begin
            done_q <= 1'b0;
        end
    end
endmodule

// File: rtl/dtw_port_drv.sv
module dtw_port_drv
    import dtw_pkg::*;
(
    input  logic             busy,
    input  step_e            step,
    input  logic [TST_W-1:0] code_q,
    input  logic [TST_W-1:0] data_q,
    output port_t            port
);
    always_comb begin
        if (busy) port = port_for_step(step, code_q, data_q);
        else      port = PORT_IDLE;
    end
endmodule

// File: rtl/dphy_tst_writer.sv
module dphy_tst_writer
    import dtw_pkg::*;
#(
    parameter int HOLD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [TST_W-1:0]  code_i,
    input  logic [TST_W-1:0]  wdata_i,
    input  logic [HOLD_W-1:0] hold_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              tst_clr_o,
    output logic              tst_clk_o,
    output logic              tst_en_o,
    output logic [TST_W-1:0]  tst_data_o
);
    logic             accept;
    logic             step_end;
    logic             busy;
    step_e            step;
    logic [TST_W-1:0] code_q;
    logic [TST_W-1:0] data_q;
    port_t            port;

    dtw_step_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start_i),
        .code_in  (code_i),
        .data_in  (wdata_i),
        .step_end (step_end),
        .accept   (accept),
        .busy     (busy),
        .done     (done_o),
        .step     (step),
        .code_q   (code_q),
        .data_q   (data_q)
    );

    dtw_hold_timer #(.HOLD_W(HOLD_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .hold_cfg (hold_i),
        .active   (busy),
        .step_end (step_end)
    );

    dtw_port_drv u_drv (
        .busy   (busy),
        .step   (step),
        .code_q (code_q),
        .data_q (data_q),
        .port   (port)
    );

    assign busy_o     = busy;
    assign tst_clr_o  = port.clr;
    assign tst_clk_o  = port.stb;
    assign tst_en_o   = port.en;
    assign tst_data_o = port.bus;
endmodule

// File: rtl/dtw_checker.sv
module dtw_checker (
    input logic       clk,
    input logic       rst,
    input logic       start_i,
    input logic       busy_o,
    input logic       done_o,
    input logic       tst_clr_o,
    input logic       tst_clk_o,
    input logic       tst_en_o,
    input logic [7:0] tst_data_o
);
    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (!busy_o && !done_o && !tst_clr_o && !tst_clk_o && !tst_en_o && tst_data_o == 8'h00));

    assert_idle_holds_R2: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !start_i) |=> !busy_o);

    assert_accept_clear_R2: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && start_i) |=> (busy_o && tst_clr_o));

    assert_en_rise_under_strobe_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(tst_en_o) |-> (tst_clk_o && $past(tst_clk_o)));

    assert_addr_edge_stable_R5: assert property (@(posedge clk) disable iff (rst)
        ($fell(tst_clk_o) && tst_en_o) |-> (tst_data_o == $past(tst_data_o) && $past(tst_en_o)));

    assert_rise_with_en_low_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(tst_clk_o) |-> (!tst_en_o && !$past(tst_en_o)));

    assert_done_not_busy_R7: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!busy_o && !tst_clk_o && !tst_en_o && !tst_clr_o));

    assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    assert_busy_start_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_i && !tst_clr_o) |=> !tst_clr_o);

    assert_clear_alone_R10: assert property (@(posedge clk) disable iff (rst)
        tst_clr_o |-> (!tst_clk_o && !tst_en_o && tst_data_o == 8'h00));
endmodule

bind dphy_tst_writer dtw_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .tst_clr_o  (tst_clr_o),
    .tst_clk_o  (tst_clk_o),
    .tst_en_o   (tst_en_o),
    .tst_data_o (tst_data_o)
);

// File: tb/dphy_tst_writer_bench.sv
module dphy_tst_writer_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [7:0] code = 8'h00;
    logic [7:0] wdata = 8'h00;
    logic [7:0] hold = 8'h01;
    logic       busy, done, tclr, tclk, ten;
    logic [7:0] tdata;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    dphy_tst_writer u_dphy_tst_writer (
        .clk(clk), .rst(rst), .start_i(start), .code_i(code), .wdata_i(wdata),
        .hold_i(hold), .busy_o(busy), .done_o(done), .tst_clr_o(tclr),
        .tst_clk_o(tclk), .tst_en_o(ten), .tst_data_o(tdata)
    );

    // behavioural reference: phase index, cycles spent in phase, latched request
    int   m_busy = 0, m_done = 0, m_phase = 0, m_cnt = 0, m_len = 1;
    int   m_code = 0, m_data = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 0; m_done = 0; m_phase = 0; m_cnt = 0;
        end else if (!m_busy && start) begin
            m_busy = 1; m_done = 0; m_phase = 0; m_cnt = 0;
            m_len = (hold == 0) ? 1 : int'(hold);
            m_code = int'(code); m_data = int'(wdata);
        end else if (m_busy) begin
            m_done = 0;
            if (m_cnt == m_len - 1) begin
                m_cnt = 0;
                if (m_phase == 7) begin m_busy = 0; m_done = 1; end
                else m_phase = m_phase + 1;
            end else m_cnt = m_cnt + 1;
        end else m_done = 0;
    end

    // expected wires as {clr, strobe, enable, bus}
    function automatic logic [10:0] expect_port();
        if (!m_busy) return 11'h0;
        case (m_phase)
            0: return {3'b100, 8'h00};
            1: return {3'b000, 8'h00};
            2: return {3'b010, 8'h00};
            3: return {3'b011, 8'(m_code)};
            4: return {3'b001, 8'(m_code)};
            5: return {3'b000, 8'(m_data)};
            6: return {3'b010, 8'(m_data)};
            default: return {3'b000, 8'(m_data)};
        endcase
    endfunction

    // PHY capture model and per-cycle comparison
    logic       prev_tclk = 1'b0;
    logic [7:0] cap_addr = 8'h00, cap_data = 8'h00;
    int         addr_falls = 0;

    always @(negedge clk) begin
        cycles++;
        if (!rst) begin
            logic [10:0] exp_p;
            exp_p = expect_port();
            checks++;
            if ({tclr, tclk, ten, tdata} !== exp_p || busy !== (m_busy != 0) || done !== (m_done != 0)) begin
                errors++;
                $display("FAIL R3/R4/R7 cycle %0d: port=%h busy=%b done=%b expected port=%h busy=%0d done=%0d",
                         cycles, {tclr, tclk, ten, tdata}, busy, done, exp_p, m_busy, m_done);
            end
            if (prev_tclk && !tclk && ten) begin cap_addr = tdata; addr_falls++; end
            if (!prev_tclk && tclk && !ten) cap_data = tdata;
        end
        prev_tclk = tclk;
    end

    task automatic check(input string tag, input int act, input int exp_v);
        checks++;
        if (act != exp_v) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp_v);
        end
    endtask

    // issue a write; optionally pulse a conflicting start mid-write
    task automatic do_write(input logic [7:0] c, input logic [7:0] d, input logic [7:0] h,
                            input bit disturb, input string tag);
        int n;
        int hh;
        hh = (h == 0) ? 1 : int'(h);
        @(negedge clk);
        code = c; wdata = d; hold = h; start = 1'b1; addr_falls = 0;
        @(negedge clk);
        start = 1'b0;
        n = 1;
        while (!done && n < 4000) begin
            if (disturb && n == 5) begin
                code = ~c; wdata = ~d; hold = 8'd2; start = 1'b1;
            end else start = 1'b0;
            @(negedge clk);
            n++;
        end
        start = 1'b0;
        check({tag, " R4 cycles to done"}, n, 8 * hh + 1);
        check({tag, " R5 captured address"}, int'(cap_addr), int'(c));
        check({tag, " R5 address edges"}, addr_falls, 1);
        check({tag, " R6 captured data"}, int'(cap_data), int'(d));
        check({tag, " R7 busy low at done"}, int'(busy), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 busy in reset", int'(busy), 0);
        check("R1 wires in reset", int'({tclr, tclk, ten, tdata}), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 idle after reset", int'({busy, done, tclr, tclk, ten, tdata}), 0);

        // R2: first state after acceptance
        code = 8'h12; wdata = 8'h34; hold = 8'd2; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R2 busy after accept", int'(busy), 1);
        check("R2 clear state", int'({tclr, tclk, ten, tdata}), 11'h400);
        check("R10 clear alone", int'({tclk, ten, tdata}), 0);
        while (!done) @(negedge clk);
        check("R7 wires low at done", int'({tclr, tclk, ten, tdata}), 0);
        @(negedge clk);
        check("R7 done single pulse", int'(done), 0);

        do_write(8'h44, 8'h2c, 8'd1, 1'b0, "R9 freq-range");
        do_write(8'hA5, 8'h5A, 8'd3, 1'b0, "R3 hold3");
        do_write(8'h0F, 8'hF0, 8'd0, 1'b0, "R4 hold0");
        do_write(8'hC3, 8'h3C, 8'd4, 1'b1, "R8 start while busy");
        do_write(8'h81, 8'h7E, 8'd255, 1'b0, "R4 hold255");

        // R7: start on the done cycle is accepted back to back
        @(negedge clk);
        code = 8'h11; wdata = 8'h22; hold = 8'd1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
        code = 8'h55; wdata = 8'h66; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R7 back-to-back accepted", int'(tclr), 1);
        while (!done) @(negedge clk);
        check("R7 back-to-back address", int'(cap_addr), 8'h55);
        check("R7 back-to-back data", int'(cap_data), 8'h66);

        repeat (4) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule